// File: doc/BRIEF.md
# Convolution Layer Sequencer

This block steers the processing of one convolution layer. A single start pulse begins a layer. The block then issues one-cycle start strobes, in order, to four data units and to the 3x3 convolution array. The data units are a weight loader, a bias loader, a feature-map row loader and a result writer. After each strobe it waits for the matching completion input. Three configuration bits are captured when the layer starts:

- zero padding, which is passed on to the feature-map loader;
- bias loading, which makes the bias step run;
- max pooling, which changes how the convolution loop ends.

The work of one weight group runs as follows. The weights are loaded, and the bias is loaded if enabled. After that the block loops: it fetches the top three rows of one channel, then convolves them. Without pooling, the loop ends when the array reports that the last channel of the pass is done. With pooling, the loop ends when the pooling window is complete. During pooling, every convolution step hands the block two result lanes. The block keeps the largest value seen in the window in a running maximum register, and the result writer reads that register. After each save, the completion flags pick the next step: back to the row loader, to the next weight group, or to idle.

The memory transfers and the arithmetic sit in the units around this block. The block itself holds only the sequence and the pooling maximum.

Top module: `conv_layer_seq`

## Requirements
- R1: After a synchronous reset, `phase` reads 0 (idle), all five strobes and `pad_en` are low, and `pool_q` holds the most negative two's-complement value (0x8000 for 16 bits).
- R2: In idle, `start` captures `cfg_pad`, `cfg_bias` and `cfg_pool` and moves `phase` to 1 (weight load) with `wgt_go` high. For the whole layer `pad_en` equals the captured padding bit, and later changes on the config inputs have no effect. `pad_en` clears on return to idle.
- R3: In phase 1, `wgt_done` moves to phase 2 (bias load) with `bias_go` if bias was captured. Otherwise it moves to phase 3 (row fetch) with `fmap_go`.
- R4: In phase 2, `bias_done` moves to phase 3 with `fmap_go`.
- R5: In phase 3, `fmap_done` moves to phase 4 (convolve) with `conv_go`.
- R6: Without pooling, `conv_done` in phase 4 moves to phase 5 (save) with `save_go` when `chan_last` is high. Otherwise it moves back to phase 3. `win_last` is ignored.
- R7: With pooling, each `conv_done` in phase 4 makes `pool_q` the signed maximum of `pool_q` and both lanes of `conv_res` (lane 0 in bits DW-1:0, lane 1 above). `win_last` then chooses phase 5 or phase 3, and `chan_last` is ignored.
- R8: In phase 5, `save_done` moves to idle when `layer_last` is high. Otherwise it moves to phase 1 with `wgt_go` when `grp_last` is high, or else to phase 3 with `fmap_go`.
- R9: `pool_q` returns to the most negative value at each layer start and at each `save_done`.
- R10: Each strobe is high only in the first cycle of its phase, and at most one strobe is high at a time. A completion input from a unit other than the one being waited on leaves the phase unchanged.
- R11: `start` has no effect outside idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Layer start pulse |
| cfg_pad | input | 1 | Zero padding enable |
| cfg_bias | input | 1 | Bias load enable |
| cfg_pool | input | 1 | Max pooling enable |
| wgt_done | input | 1 | Weight loader finished |
| bias_done | input | 1 | Bias loader finished |
| fmap_done | input | 1 | Row loader finished |
| conv_done | input | 1 | Array finished one row block |
| save_done | input | 1 | Result writer finished |
| chan_last | input | 1 | With conv_done: last channel of this pass |
| win_last | input | 1 | With conv_done: pooling window complete |
| grp_last | input | 1 | With save_done: weight group finished |
| layer_last | input | 1 | With save_done: layer finished |
| conv_res | input | LANES*DW | Two signed result lanes from the array |
| phase | output | 3 | Current phase: 0 idle, 1 weight, 2 bias, 3 rows, 4 convolve, 5 save |
| wgt_go | output | 1 | Weight loader start strobe |
| bias_go | output | 1 | Bias loader start strobe |
| fmap_go | output | 1 | Row loader start strobe |
| conv_go | output | 1 | Array start strobe |
| save_go | output | 1 | Result writer start strobe |
| pad_en | output | 1 | Captured padding mode for the layer |
| pool_q | output | DW | Running pooling maximum |

## Verification
The properties assume well-behaved neighbours. A completion input arrives at least one cycle after its strobe. `start` and the completion pulses last one cycle. The qualifier flags are only meaningful in the cycle of their completion pulse. The stub units in the bench wait one to three cycles before answering. During that wait they send a completion from a different unit and a repeated `start`, to probe the ignore rules. They never send two completions from the awaited unit, and they never raise a completion in the same cycle as its strobe.

// File: rtl/cls_pkg.sv
package cls_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_LWB  = 3'd1,
    PH_LBB  = 3'd2,
    PH_LFB  = 3'd3,
    PH_CONV = 3'd4,
    PH_SRB  = 3'd5
  } phase_t;

  localparam int NUNIT = 5;
endpackage

// File: rtl/cls_fsm.sv
module cls_fsm
  import cls_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  input  logic   cfg_pad,
  input  logic   cfg_bias,
  input  logic   cfg_pool,
  input  logic   wgt_done,
  input  logic   bias_done,
  input  logic   fmap_done,
  input  logic   conv_done,
  input  logic   save_done,
  input  logic   chan_last,
  input  logic   win_last,
  input  logic   grp_last,
  input  logic   layer_last,
  output phase_t st,
  output phase_t nxt,
  output logic   pad_on,
  output logic   pool_upd,
  output logic   win_init
);
  logic bias_on;
  logic pool_on;
  logic loop_end;

  // the loop exit flag depends on the pooling mode
  assign loop_end = pool_on ? win_last : chan_last;

  always_comb begin
    nxt = st;
    unique case (st)
      PH_IDLE: if (start)     nxt = PH_LWB;
      PH_LWB:  if (wgt_done)  nxt = bias_on ? PH_LBB : PH_LFB;
      PH_LBB:  if (bias_done) nxt = PH_LFB;
      PH_LFB:  if (fmap_done) nxt = PH_CONV;
      PH_CONV: if (conv_done) nxt = loop_end ? PH_SRB : PH_LFB;
      PH_SRB:  if (save_done) nxt = layer_last ? PH_IDLE :
                                    (grp_last ? PH_LWB : PH_LFB);
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= PH_IDLE;
      pad_on  <= 1'b0;
      bias_on <= 1'b0;
      pool_on <= 1'b0;
    end else begin
      st <= nxt;
      if (st == PH_IDLE && start) begin
        pad_on  <= cfg_pad;
        bias_on <= cfg_bias;
        pool_on <= cfg_pool;
      end else if (st != PH_IDLE && nxt == PH_IDLE) begin
        pad_on  <= 1'b0;
        bias_on <= 1'b0;
        pool_on <= 1'b0;
      end
    end
  end

  assign pool_upd = (st == PH_CONV) && conv_done && pool_on;
  assign win_init = ((st == PH_IDLE) && start) || ((st == PH_SRB) && save_done);
endmodule

// File: rtl/cls_strobe.sv
module cls_strobe
  import cls_pkg::*;
#(
  parameter int N = NUNIT
) (
  input  logic         clk,
  input  logic         rst,
  input  phase_t       st,
  input  phase_t       nxt,
  output logic [N-1:0] go
);
  // unit i owns phase i+1; its strobe rises on entry into that phase only
  for (genvar i = 0; i < N; i++) begin : g_unit
    always_ff @(posedge clk) begin
      if (rst) go[i] <= 1'b0;
      else     go[i] <= (nxt != st) && (nxt == phase_t'(i + 1));
    end
  end
endmodule

// File: rtl/cls_poolmax.sv
module cls_poolmax #(
  parameter int DW    = 16,
  parameter int LANES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                init,
  input  logic                upd,
  input  logic [LANES*DW-1:0] lanes,
  output logic [DW-1:0]       q
);
  localparam logic [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

  logic signed [DW-1:0] cand [0:LANES];
  assign cand[0] = $signed(q);

  for (genvar i = 0; i < LANES; i++) begin : g_cmp
    logic signed [DW-1:0] lane_v;
    assign lane_v     = $signed(lanes[i*DW +: DW]);
    assign cand[i+1]  = (lane_v > cand[i]) ? lane_v : cand[i];
  end

  always_ff @(posedge clk) begin
    if (rst || init) q <= MINV;
    else if (upd)    q <= cand[LANES];
  end
endmodule

// File: rtl/conv_layer_seq.sv
module conv_layer_seq
  import cls_pkg::*;
#(
  parameter int DW    = 16,
  parameter int LANES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                cfg_pad,
  input  logic                cfg_bias,
  input  logic                cfg_pool,
  input  logic                wgt_done,
  input  logic                bias_done,
  input  logic                fmap_done,
  input  logic                conv_done,
  input  logic                save_done,
  input  logic                chan_last,
  input  logic                win_last,
  input  logic                grp_last,
  input  logic                layer_last,
  input  logic [LANES*DW-1:0] conv_res,
  output logic [2:0]          phase,
  output logic                wgt_go,
  output logic                bias_go,
  output logic                fmap_go,
  output logic                conv_go,
  output logic                save_go,
  output logic                pad_en,
  output logic [DW-1:0]       pool_q
);
  phase_t           st;
  phase_t           nxt;
  logic             pool_upd;
  logic             win_init;
  logic [NUNIT-1:0] go;

  cls_fsm u_fsm (
    .clk(clk), .rst(rst), .start(start),
    .cfg_pad(cfg_pad), .cfg_bias(cfg_bias), .cfg_pool(cfg_pool),
    .wgt_done(wgt_done), .bias_done(bias_done), .fmap_done(fmap_done),
    .conv_done(conv_done), .save_done(save_done),
    .chan_last(chan_last), .win_last(win_last),
    .grp_last(grp_last), .layer_last(layer_last),
    .st(st), .nxt(nxt), .pad_on(pad_en),
    .pool_upd(pool_upd), .win_init(win_init)
  );

  cls_strobe #(.N(NUNIT)) u_strobe (
    .clk(clk), .rst(rst), .st(st), .nxt(nxt), .go(go)
  );

  cls_poolmax #(.DW(DW), .LANES(LANES)) u_pool (
    .clk(clk), .rst(rst), .init(win_init), .upd(pool_upd),
    .lanes(conv_res), .q(pool_q)
  );

  assign phase   = st;
  assign wgt_go  = go[0];
  assign bias_go = go[1];
  assign fmap_go = go[2];
  assign conv_go = go[3];
  assign save_go = go[4];
endmodule

// File: rtl/cls_chk.sv
module cls_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          fmap_done,
  input logic          conv_done,
  input logic          save_done,
  input logic          layer_last,
  input logic [2:0]    phase,
  input logic          wgt_go,
  input logic          bias_go,
  input logic          fmap_go,
  input logic          conv_go,
  input logic          save_go,
  input logic [DW-1:0] pool_q
);
  // R10
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wgt_go, bias_go, fmap_go, conv_go, save_go}));

  // R10
  wgt_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wgt_go |=> !wgt_go);

  // R10
  conv_go_phase_chk: assert property (@(posedge clk) disable iff (rst)
    conv_go |-> phase == 3'd4);

  // R2
  start_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd0 && start) |=> (phase == 3'd1 && wgt_go));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd0 && !start) |=> phase == 3'd0);

  // R5
  rows_to_conv_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd3 && fmap_done) |=> (phase == 3'd4 && conv_go));

  // R8
  layer_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd5 && save_done && layer_last) |=> phase == 3'd0);

  // R7
  pool_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd4 && !conv_done) |=> $stable(pool_q));
endmodule

bind conv_layer_seq cls_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .start(start),
  .fmap_done(fmap_done), .conv_done(conv_done), .save_done(save_done),
  .layer_last(layer_last), .phase(phase),
  .wgt_go(wgt_go), .bias_go(bias_go), .fmap_go(fmap_go),
  .conv_go(conv_go), .save_go(save_go), .pool_q(pool_q)
);

// File: tb/sim_conv_layer_seq.sv
module sim_conv_layer_seq;
  localparam int DW = 16;
  localparam int LANES = 2;
  localparam logic [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, cfg_pad = 1'b0, cfg_bias = 1'b0, cfg_pool = 1'b0;
  logic [4:0] dn = '0;
  logic chan_last = 1'b0, win_last = 1'b0, grp_last = 1'b0, layer_last = 1'b0;
  logic [LANES*DW-1:0] conv_res = '0;
  logic [2:0] phase;
  logic wgt_go, bias_go, fmap_go, conv_go, save_go, pad_en;
  logic [DW-1:0] pool_q;
  logic [4:0] gov;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  assign gov = {save_go, conv_go, fmap_go, bias_go, wgt_go};

  conv_layer_seq #(.DW(DW), .LANES(LANES)) u0 (
    .clk(clk), .rst(rst), .start(start),
    .cfg_pad(cfg_pad), .cfg_bias(cfg_bias), .cfg_pool(cfg_pool),
    .wgt_done(dn[0]), .bias_done(dn[1]), .fmap_done(dn[2]),
    .conv_done(dn[3]), .save_done(dn[4]),
    .chan_last(chan_last), .win_last(win_last),
    .grp_last(grp_last), .layer_last(layer_last),
    .conv_res(conv_res), .phase(phase),
    .wgt_go(wgt_go), .bias_go(bias_go), .fmap_go(fmap_go),
    .conv_go(conv_go), .save_go(save_go),
    .pad_en(pad_en), .pool_q(pool_q)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic expect_entry(input int ph, input string req);
    chk(phase == 3'(ph), req, int'(phase), ph);
    chk(gov == (5'b1 << (ph - 1)), req, int'(gov), 1 << (ph - 1));
  endtask

  // stub for unit u: waits, sends stray inputs, then completes
  task automatic serve(input int u, input bit f_chan, input bit f_win,
                       input bit f_grp, input bit f_layer);
    int d;
    d = $urandom_range(1, 3);
    for (int k = 0; k < d; k++) begin
      dn = 5'b1 << ((u + 1 + $urandom_range(0, 3)) % 5);
      start = 1'b1;
      tick();
      dn = '0;
      start = 1'b0;
      chk(phase == 3'(u + 1), "R10 R11 stray input", int'(phase), u + 1);
      chk(gov == 5'b0, "R10 strobe width", int'(gov), 0);
    end
    dn = 5'b1 << u;
    chan_last = f_chan; win_last = f_win; grp_last = f_grp; layer_last = f_layer;
    tick();
    dn = '0;
    chan_last = 1'b0; win_last = 1'b0; grp_last = 1'b0; layer_last = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    chk(phase == 3'd0, "R1 phase", int'(phase), 0);
    chk(gov == 5'b0, "R1 strobes", int'(gov), 0);
    chk(pad_en == 1'b0, "R1 pad_en", int'(pad_en), 0);
    chk(pool_q == MINV, "R1 pool_q", int'(pool_q), int'(MINV));
  endtask

  task automatic t_layer(input bit pad, input bit bias, input bit pool,
                         input int groups, input int passes, input int iters);
    logic signed [DW-1:0] emax, a, b;
    string why;
    cfg_pad = pad; cfg_bias = bias; cfg_pool = pool;
    start = 1'b1;
    tick();
    start = 1'b0;
    cfg_pad = ~pad; cfg_bias = ~bias; cfg_pool = ~pool;
    expect_entry(1, "R2 start");
    chk(pad_en == pad, "R2 pad_en", int'(pad_en), int'(pad));
    chk(pool_q == MINV, "R9 layer start", int'(pool_q), int'(MINV));
    emax = MINV;
    for (int g = 0; g < groups; g++) begin
      for (int p = 0; p < passes; p++) begin
        if (p == 0) begin
          serve(0, 0, 0, 0, 0);
          if (bias) begin
            expect_entry(2, "R3 bias");
            serve(1, 0, 0, 0, 0);
            why = "R4";
          end else why = "R3 no bias";
        end else why = "R8 to rows";
        for (int i = 0; i < iters; i++) begin
          bit last;
          last = (i == iters - 1);
          expect_entry(3, why);
          serve(2, 0, 0, 0, 0);
          expect_entry(4, "R5");
          a = DW'($urandom);
          b = DW'($urandom);
          conv_res = {b, a};
          if (pool) begin
            serve(3, 1'($urandom), last, 0, 0);
            if (a > emax) emax = a;
            if (b > emax) emax = b;
            why = "R7 loop";
          end else begin
            serve(3, last, 1'($urandom), 0, 0);
            why = "R6 loop";
          end
        end
        expect_entry(5, pool ? "R7 exit" : "R6 exit");
        chk(pad_en == pad, "R2 pad_en held", int'(pad_en), int'(pad));
        if (pool) chk(pool_q == emax, "R7 max", int'(pool_q), int'(emax));
        serve(4, 0, 0, p == passes - 1, (g == groups - 1) && (p == passes - 1));
        chk(pool_q == MINV, "R9 after save", int'(pool_q), int'(MINV));
        emax = MINV;
        if (p == passes - 1 && g < groups - 1) expect_entry(1, "R8 to weights");
      end
    end
    chk(phase == 3'd0, "R8 to idle", int'(phase), 0);
    chk(gov == 5'b0, "R8 idle strobes", int'(gov), 0);
    chk(pad_en == 1'b0, "R2 pad_en cleared", int'(pad_en), 0);
    tick();
    chk(phase == 3'd0, "R11 idle hold", int'(phase), 0);
  endtask

  // pooling with every lane at the most negative value keeps it
  task automatic t_pool_floor();
    cfg_pool = 1'b1; cfg_bias = 1'b0; cfg_pad = 1'b0;
    start = 1'b1;
    tick();
    start = 1'b0;
    serve(0, 0, 0, 0, 0);
    serve(2, 0, 0, 0, 0);
    conv_res = {MINV, MINV};
    serve(3, 0, 1, 0, 0);
    expect_entry(5, "R7 floor");
    chk(pool_q == MINV, "R7 floor value", int'(pool_q), int'(MINV));
    serve(4, 0, 0, 1, 1);
    chk(phase == 3'd0, "R8 floor idle", int'(phase), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    for (int c = 0; c < 8; c++) begin
      t_layer(c[0], c[1], c[2], 2, 2, c[2] ? 4 : 3);
    end
    t_layer(1'b1, 1'b1, 1'b1, 1, 1, 1);
    t_pool_floor();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule